// File: doc/BRIEF.md
# Thread Wakeup Event Unit

This unit lets every hardware thread of a multi-threaded core park itself until an event it cares about arrives. The core does not take an interrupt and does not switch context. Software sets a per-thread enable mask over three event sources:

- an inter-processor interrupt line;
- a messaging-unit interrupt line;
- cache-line invalidation notices, which count only when the line address equals one of a few armed watch registers that belong to the thread.

Every event that arrives is latched as a pending bit, whether or not its source is enabled. The unit drives one run/stop level per thread back to the core. A thread that asks to sleep while an enabled event is already pending keeps running, so a wakeup that comes early is never lost.

Software programs the unit through a single register write port. Each write carries a thread number, a register select and data. Select 0 writes the enable mask. Select 1 clears pending bits where the data holds ones (write-one-to-clear). Selects 2 and up write the watch registers. A watch write carries an arm bit at data bit ADDR_W and the line address in the bits below it.

Invalidation notices come in as a valid-qualified address stream. The unit compares every notice in the cycle it arrives and applies no back-pressure, so there is no ready signal. The interrupt lines are plain per-thread levels, and each is sampled on every clock edge.

Top module: `wakeup_unit`

## Requirements
- R1: After reset every run output is 1, every pending bit is 0, every mask is 0 and every watch register is disarmed.
- R2: When ipi[t] is high at a clock edge, pending[t*3+0] is 1 after that edge. When mu_irq[t] is high at a clock edge, pending[t*3+1] is 1 after that edge.
- R3: When inv_valid is high and inv_addr equals the address of an armed watch register of thread t, pending[t*3+2] is set at that edge. A notice that matches no armed watch register of thread t leaves that bit unchanged.
- R4: A write with wr_sel=1 to thread t clears each pending bit of t whose data bit (0 to 2) is 1, at that edge. Data bits that are 0 leave the matching pending bits unchanged.
- R5: If an event sets a pending bit in the same cycle as a clear of that bit, the bit stays 1.
- R6: When sleep_req[t] is high while run[t] is 1, and no enabled pending bit exists (counting events arriving in that same cycle), run[t] is 0 after that edge.
- R7: When sleep_req[t] is high while run[t] is 1, and an enabled pending bit exists (including one arriving in that same cycle), run[t] stays 1.
- R8: A stopped thread whose pending bits, after the event cycle, include one enabled by its mask has run[t] = 1 after that edge.
- R9: An event from a disabled source is latched and leaves a stopped thread stopped. A later mask write that enables that source wakes the thread on the second edge after the write.
- R10: Events, writes and sleep requests aimed at one thread change neither the pending bits nor the run output of any other thread.
- R11: A sleep request on a thread that is already stopped has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_thread | input | TID_W | Thread addressed by the write |
| wr_sel | input | SEL_W | 0 mask, 1 clear pending, 2+k watch register k |
| wr_data | input | ADDR_W+1 | Write data; for a watch write, bit ADDR_W is the arm bit |
| ipi | input | NT | Per-thread inter-processor interrupt |
| mu_irq | input | NT | Per-thread messaging-unit interrupt |
| inv_valid | input | 1 | Invalidation notice valid |
| inv_addr | input | ADDR_W | Invalidated line address |
| sleep_req | input | NT | Per-thread suspend request |
| run | output | NT | 1 = thread may run, 0 = thread suspended |
| pending | output | NT*3 | Pending bits, thread t in bits t*3 to t*3+2 (IPI, messaging, invalidation) |

## Verification
Two pairs of functions can fall in the same cycle.

- **Event arriving with a clear of the same bit.** This is the set-over-clear rule. The bench provokes it by driving an interrupt in the same cycle as a write-one-to-clear of that bit. The bit must read 1 afterwards.
- **Suspend request meeting a same-cycle event.** This is the no-lost-wakeup rule. The bench raises sleep_req and an enabled interrupt together. run must stay 1.

Random traffic then mixes all inputs on all threads. The result is compared every cycle against a bench model built from the requirements, which judges each coincidence the random traffic produces.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int NSRC    = 3;
  localparam int SRC_IPI = 0;
  localparam int SRC_MU  = 1;
  localparam int SRC_INV = 2;

  localparam int SEL_MASK  = 0;
  localparam int SEL_CLEAR = 1;
  localparam int SEL_WATCH = 2;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/wk_watch_match.sv
module wk_watch_match #(
  parameter int NWATCH = 2,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWATCH-1:0] wr_watch,
  input  logic [ADDR_W:0]   wr_data,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              hit
);
  logic [NWATCH-1:0] armed_q;
  logic [NWATCH-1:0] match;

  for (genvar k = 0; k < NWATCH; k++) begin : g_slot
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        armed_q[k] <= 1'b0;
        addr_q     <= '0;
      end else if (wr_watch[k]) begin
        armed_q[k] <= wr_data[ADDR_W];
        addr_q     <= wr_data[ADDR_W-1:0];
      end
    end

    assign match[k] = armed_q[k] && (addr_q == inv_addr);
  end

  assign hit = inv_valid && (|match);
endmodule

// File: rtl/wk_thread_ctl.sv
module wk_thread_ctl
  import wk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_i,
  input  logic     wr_mask,
  input  logic     wr_clear,
  input  src_vec_t wr_bits,
  input  logic     sleep_req,
  output logic     run,
  output src_vec_t pend,
  output src_vec_t mask
);
  src_vec_t clr;
  src_vec_t pend_nxt;
  logic     wake_cond;

  // An arriving event wins over a same-cycle clear.
  assign clr       = wr_clear ? wr_bits : '0;
  assign pend_nxt  = (pend & ~clr) | set_i;
  assign wake_cond = |(pend_nxt & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
      run  <= 1'b1;
    end else begin
      pend <= pend_nxt;
      if (wr_mask) mask <= wr_bits;
      if (run) begin
        if (sleep_req && !wake_cond) run <= 1'b0;
      end else if (wake_cond) begin
        run <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wakeup_unit.sv
module wakeup_unit
  import wk_pkg::*;
#(
  parameter int NT     = 4,
  parameter int NWATCH = 2,
  parameter int ADDR_W = 16,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1,
  localparam int SEL_W = $clog2(NWATCH + SEL_WATCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TID_W-1:0]  wr_thread,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W:0]   wr_data,
  input  logic [NT-1:0]     ipi,
  input  logic [NT-1:0]     mu_irq,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic [NT-1:0]     sleep_req,
  output logic [NT-1:0]     run,
  output logic [NT*NSRC-1:0] pending
);
  logic [NT*NSRC-1:0] thr_mask;

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic              sel_me;
    logic [NWATCH-1:0] wr_watch;
    logic              inv_hit;
    src_vec_t          set_v;
    src_vec_t          pend_v;
    src_vec_t          mask_v;

    assign sel_me = wr_en && (wr_thread == TID_W'(t));

    for (genvar k = 0; k < NWATCH; k++) begin : g_wsel
      assign wr_watch[k] = sel_me && (wr_sel == SEL_W'(SEL_WATCH + k));
    end

    wk_watch_match #(.NWATCH(NWATCH), .ADDR_W(ADDR_W)) i_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_watch  (wr_watch),
      .wr_data   (wr_data),
      .inv_valid (inv_valid),
      .inv_addr  (inv_addr),
      .hit       (inv_hit)
    );

    always_comb begin
      set_v          = '0;
      set_v[SRC_IPI] = ipi[t];
      set_v[SRC_MU]  = mu_irq[t];
      set_v[SRC_INV] = inv_hit;
    end

    wk_thread_ctl i_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_v),
      .wr_mask   (sel_me && (wr_sel == SEL_W'(SEL_MASK))),
      .wr_clear  (sel_me && (wr_sel == SEL_W'(SEL_CLEAR))),
      .wr_bits   (wr_data[NSRC-1:0]),
      .sleep_req (sleep_req[t]),
      .run       (run[t]),
      .pend      (pend_v),
      .mask      (mask_v)
    );

    assign pending[t*NSRC +: NSRC]  = pend_v;
    assign thr_mask[t*NSRC +: NSRC] = mask_v;
  end
endmodule

// File: rtl/wakeup_unit_chk.sv
module wakeup_unit_chk #(
  parameter int NT    = 4,
  parameter int TID_W = 2,
  parameter int SEL_W = 2,
  parameter int DW    = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [TID_W-1:0] wr_thread,
  input logic [SEL_W-1:0] wr_sel,
  input logic [DW-1:0]    wr_data,
  input logic [NT-1:0]    ipi,
  input logic [NT-1:0]    mu_irq,
  input logic [NT-1:0]    sleep_req,
  input logic [NT-1:0]    run,
  input logic [NT*3-1:0]  pending,
  input logic [NT*3-1:0]  thr_mask
);
  for (genvar t = 0; t < NT; t++) begin : g_t
    logic clr_here;
    assign clr_here = wr_en && (wr_sel == SEL_W'(1)) && (wr_thread == TID_W'(t));

    // R2, R5: an interrupt is latched even if cleared in the same cycle
    a_r2_ipi_latched: assert property (@(posedge clk) disable iff (!rst_n)
      ipi[t] |=> pending[t*3]);
    a_r2_mu_latched: assert property (@(posedge clk) disable iff (!rst_n)
      mu_irq[t] |=> pending[t*3+1]);
    // R4
    a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_here && wr_data[0] && !ipi[t]) |=> !pending[t*3]);
    // R6, R11: a thread only stops on its own request
    a_r6_stop_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run[t]) |-> $past(sleep_req[t]));
    // R8, R9: a thread only wakes on an enabled pending event
    a_r8_wake_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run[t]) |-> |(pending[t*3 +: 3] & $past(thr_mask[t*3 +: 3])));
    // R7
    a_r7_no_lost_wakeup: assert property (@(posedge clk) disable iff (!rst_n)
      (run[t] && sleep_req[t] && |(pending[t*3 +: 3] & thr_mask[t*3 +: 3]) && !clr_here)
        |=> run[t]);
  end
endmodule

bind wakeup_unit wakeup_unit_chk #(
  .NT(NT), .TID_W(TID_W), .SEL_W(SEL_W), .DW(ADDR_W + 1)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_thread(wr_thread),
  .wr_sel(wr_sel), .wr_data(wr_data), .ipi(ipi), .mu_irq(mu_irq),
  .sleep_req(sleep_req), .run(run), .pending(pending), .thr_mask(thr_mask)
);

// File: tb/test_wakeup_unit.sv
`timescale 1ns/1ps
module test_wakeup_unit;
  localparam int NT = 4, NW = 2, AW = 16, TW = 2, SW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [TW-1:0] wr_thread;
  logic [SW-1:0] wr_sel;
  logic [AW:0] wr_data;
  logic [NT-1:0] ipi, mu_irq, sleep_req, run;
  logic inv_valid;
  logic [AW-1:0] inv_addr;
  logic [NT*3-1:0] pending;

  always #2.5 clk = ~clk;

  wakeup_unit #(.NT(NT), .NWATCH(NW), .ADDR_W(AW)) i_wakeup_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_thread(wr_thread),
    .wr_sel(wr_sel), .wr_data(wr_data), .ipi(ipi), .mu_irq(mu_irq),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .sleep_req(sleep_req),
    .run(run), .pending(pending)
  );

  // reference model
  logic [2:0] m_pend [NT];
  logic [2:0] m_mask [NT];
  logic [NT-1:0] m_run;
  logic [AW-1:0] m_waddr [NT][NW];
  logic m_warm [NT][NW];

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [NT*3-1:0] exp_pend();
    logic [NT*3-1:0] v;
    for (int t = 0; t < NT; t++) v[t*3 +: 3] = m_pend[t];
    return v;
  endfunction

  task automatic model_reset();
    m_run = '1;
    for (int t = 0; t < NT; t++) begin
      m_pend[t] = 0; m_mask[t] = 0;
      for (int k = 0; k < NW; k++) begin m_waddr[t][k] = 0; m_warm[t][k] = 0; end
    end
  endtask

  task automatic model_step();
    for (int t = 0; t < NT; t++) begin
      logic [2:0] set, clr, pn;
      logic hit, me, wake;
      hit = 0;
      for (int k = 0; k < NW; k++)
        if (inv_valid && m_warm[t][k] && m_waddr[t][k] == inv_addr) hit = 1;
      set = {hit, mu_irq[t], ipi[t]};
      me = wr_en && (wr_thread == TW'(t));
      clr = (me && wr_sel == 1) ? wr_data[2:0] : 3'b000;
      pn = (m_pend[t] & ~clr) | set;
      wake = |(pn & m_mask[t]);
      if (m_run[t] && sleep_req[t] && !wake) m_run[t] = 0;
      else if (!m_run[t] && wake) m_run[t] = 1;
      m_pend[t] = pn;
      if (me && wr_sel == 0) m_mask[t] = wr_data[2:0];
      for (int k = 0; k < NW; k++)
        if (me && wr_sel == SW'(2 + k)) begin
          m_warm[t][k] = wr_data[AW]; m_waddr[t][k] = wr_data[AW-1:0];
        end
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_thread = 0; wr_sel = 0; wr_data = 0;
    ipi = 0; mu_irq = 0; sleep_req = 0; inv_valid = 0; inv_addr = 0;
  endtask

  task automatic check(string tag);
    checks++;
    if (run !== m_run || pending !== exp_pend()) begin
      fails++;
      $display("FAIL %s: run=%b pending=%b expected run=%b pending=%b",
               tag, run, pending, m_run, exp_pend());
    end
  endtask

  // inputs already driven; apply one edge, then compare at the falling edge
  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag);
    idle();
  endtask

  task automatic wr(int t, int sel, logic [AW:0] d);
    wr_en = 1; wr_thread = TW'(t); wr_sel = SW'(sel); wr_data = d;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    idle();
    rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check("R1 reset state");

    // thread 0: enable IPI only, then sleep with nothing pending
    wr(0, 0, 17'h1);            step("R1 mask write");
    sleep_req[0] = 1;           step("R6 sleep stops thread");
    mu_irq[0] = 1;              step("R9 disabled source latched, stays stopped");
    step("R9 still stopped");
    wr(0, 0, 17'h3);            step("R9 mask write edge");
    step("R9 wake on second edge after mask write");
    wr(0, 1, 17'h2);            step("R4 clear messaging bit");
    ipi[0] = 1; wr(0, 1, 17'h1); step("R5 set beats clear");
    sleep_req[0] = 1;           step("R7 sleep with pending returns at once");
    wr(0, 1, 17'h7);            step("R4 clear all");
    wr(0, 1, 17'h0);            step("R4 zero clear has no effect");

    // thread 1: event in the same cycle as the sleep request
    wr(1, 0, 17'h1);            step("R10 mask thread 1");
    sleep_req[1] = 1; ipi[1] = 1; step("R7 same-cycle event keeps running");
    wr(1, 1, 17'h1);            step("R4 clear thread 1");
    sleep_req[1] = 1;           step("R6 thread 1 stops");
    sleep_req[1] = 1;           step("R11 sleep while stopped");
    ipi[1] = 1;                 step("R8 ipi wakes thread 1");

    // thread 2: watched invalidation
    wr(2, 2, {1'b1, 16'h1234}); step("R3 arm watch 0");
    wr(2, 3, {1'b0, 16'h5555}); step("R3 disarmed watch 1");
    wr(2, 0, 17'h4);            step("R3 mask thread 2");
    sleep_req[2] = 1;           step("R6 thread 2 stops");
    inv_valid = 1; inv_addr = 16'h1235; step("R3 unmatched address ignored");
    inv_valid = 1; inv_addr = 16'h5555; step("R3 disarmed slot ignored");
    inv_valid = 0; inv_addr = 16'h1234; step("R3 invalid notice ignored");
    inv_valid = 1; inv_addr = 16'h1234; step("R8 watched invalidation wakes thread 2");
    mu_irq[3] = 1;              step("R10 thread 3 event isolated");

    // constrained random traffic
    begin
      int unsigned seed = 32'd1357;
      void'($urandom(seed));
      for (int i = 0; i < 600; i++) begin
        ipi = NT'($urandom) & NT'($urandom);
        mu_irq = NT'($urandom) & NT'($urandom) & NT'($urandom);
        sleep_req = NT'($urandom);
        if ($urandom % 4 == 0) begin
          wr($urandom % NT, $urandom % 4,
             {1'($urandom), 14'h0, 2'($urandom)} | 17'($urandom % 8));
        end
        inv_valid = ($urandom % 3 == 0);
        inv_addr = {14'h0, 2'($urandom)};
        step("R10 random mix");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule